// File: doc/BRIEF.md
# I2C Word Register Target

This block is an I2C bus target with a fixed 7-bit device address. It connects a bank of 16-bit registers to the bus, and each register is selected by an 8-bit sub-address. The block samples SCL and SDA on the system clock and recognises START and STOP conditions. It drives SDA only through an open-drain pull-down enable. The register contents live outside the block. A write presents the address, the data and a one-cycle strobe on a register-file port. A read takes its data from the same port through a combinational read.

A write frame carries a sub-address and then exactly one 16-bit word, most significant byte first. Any further bytes are acknowledged and then discarded. A read can follow a sub-address written after a repeated START. It can also start directly with the read address, which re-reads the most recently acknowledged sub-address. An ordinary register read for more than two bytes returns its high and low bytes in turn. One address is reserved for a byte stream. Every byte read from it is the current head of an external ancillary-data queue and removes that head.

Top module: `i2c_word_target`

## Requirements
- R1: After reset the block does not pull SDA low and issues no register write strobe and no stream pop.
- R2: An address byte whose upper seven bits equal 7'b0110100 is acknowledged. Any other address is not acknowledged, and the block then stays off the bus and writes nothing until the next START.
- R3: In a write frame (address with bit0 = 0, sub-address, high byte, low byte), every byte is acknowledged. Exactly one single-cycle write strobe follows the acknowledge clock of the low byte, with the address equal to the sub-address and the data equal to {high, low}. No strobe appears before the low byte.
- R4: Data bytes after the second one in a write frame are acknowledged and cause no further strobe and no change to the written word.
- R5: A word read (sub-address write, repeated START, address with bit0 = 1) returns the high byte and then the low byte of the selected register, MSB first.
- R6: A read frame that starts directly with address+R returns the register at the last acknowledged sub-address.
- R7: A read of an ordinary register that continues past two bytes repeats the word, so the bytes alternate high, low, high and so on.
- R8: Reads at the stream sub-address 0x04 return the queue head for every byte, with one pop pulse per byte placed on the bus. Consecutive bytes are consecutive queue entries.
- R9: A master NACK ends the read. No further SDA drive and no further pop occur until a new START or STOP, whatever SCL does.
- R10: A STOP received before the low byte's acknowledge cancels the write, and a START at any point restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| reg_addr | output | 8 | Register address for writes and reads (current sub-address) |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 16 | Word to write |
| reg_rdata | input | 16 | Word read from reg_addr |
| anc_pop | output | 1 | Removes the head of the ancillary-data queue |
| anc_byte | input | 8 | Current head of the ancillary-data queue |

## Verification
Two things happen together at the falling SCL edge that closes a master acknowledge during a stream read. The block removes the queue head, and in the same cycle it loads the next byte and drives that byte's MSB. If those two steps were ordered wrongly, the stream would skip entries or send the same entry twice. The bench provokes this by acknowledging several stream bytes in a row. It judges the result by comparing every byte received with a queue model that advances only on pop pulses, and by requiring exactly one pop per byte. After a NACK it keeps toggling SCL and confirms that neither SDA nor the pop line moves.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int CNT_W  = $clog2(BYTE_W) + 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } state_t;

    // Bus events seen after synchronisation
    typedef struct packed {
        logic scl_hi;
        logic scl_rise;
        logic scl_fall;
        logic sda;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

endpackage

// File: rtl/i2cw_line_sync.sv
module i2cw_line_sync
    import i2cw_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t lev
);
    // [STAGES-1] is the synchronised level, [STAGES] the previous one
    logic [STAGES:0] scl_q;
    logic [STAGES:0] sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[STAGES-1:0], scl_i};
            sda_q <= {sda_q[STAGES-1:0], sda_i};
        end
    end

    always_comb begin
        lev.scl_hi   = scl_q[STAGES-1];
        lev.scl_rise = scl_q[STAGES-1] & ~scl_q[STAGES];
        lev.scl_fall = ~scl_q[STAGES-1] & scl_q[STAGES];
        lev.sda      = sda_q[STAGES-1];
        lev.start    = scl_q[STAGES-1] & scl_q[STAGES] & sda_q[STAGES] & ~sda_q[STAGES-1];
        lev.stop     = scl_q[STAGES-1] & scl_q[STAGES] & ~sda_q[STAGES] & sda_q[STAGES-1];
    end

endmodule

// File: rtl/i2cw_fsm.sv
module i2cw_fsm
    import i2cw_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR = 7'h34,
    parameter logic [BYTE_W-1:0] ANC_ADDR = 8'h04
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          lev,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_addr,
    output logic              reg_we,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] reg_rdata,
    output logic              anc_pop,
    input  logic [BYTE_W-1:0] anc_byte
);
    localparam logic [CNT_W-1:0] RX_LAST = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] TX_LAST = CNT_W'(BYTE_W - 1);

    state_t            st;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-2:0] tx;
    logic [BYTE_W-1:0] ptr_q, hi_q, lo_q;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        wcnt;
    logic              rw_q, rsel_q, mack_q;

    logic              is_anc, rx_done, rx_state;
    logic [BYTE_W-1:0] nxt;

    always_comb begin
        is_anc   = (ptr_q == ANC_ADDR);
        nxt      = is_anc ? anc_byte
                 : (rsel_q ? reg_rdata[BYTE_W-1:0] : reg_rdata[WORD_W-1:BYTE_W]);
        rx_done  = lev.scl_fall && (cnt == RX_LAST);
        rx_state = (st == ST_ADDR) || (st == ST_SUB) || (st == ST_WDATA);
    end

    assign reg_addr  = ptr_q;
    assign reg_wdata = {hi_q, lo_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            sh      <= '0;
            tx      <= '0;
            ptr_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            cnt     <= '0;
            wcnt    <= '0;
            rw_q    <= 1'b0;
            rsel_q  <= 1'b0;
            mack_q  <= 1'b0;
            sda_oe  <= 1'b0;
            reg_we  <= 1'b0;
            anc_pop <= 1'b0;
        end else begin
            reg_we  <= 1'b0;
            anc_pop <= 1'b0;
            if (lev.start) begin
                st     <= ST_ADDR;
                cnt    <= '0;
                rsel_q <= 1'b0;
                sda_oe <= 1'b0;
            end else if (lev.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                if (lev.scl_rise && rx_state) begin
                    sh  <= {sh[BYTE_W-2:0], lev.sda};
                    cnt <= cnt + 1'b1;
                end
                case (st)
                    ST_ADDR: if (rx_done) begin
                        if (addr_hit(sh, DEV_ADDR)) begin
                            sda_oe <= 1'b1;
                            rw_q   <= sh[0];
                            st     <= ST_ADDR_ACK;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                    ST_ADDR_ACK: if (lev.scl_fall) begin
                        cnt <= '0;
                        if (rw_q) begin
                            tx      <= nxt[BYTE_W-2:0];
                            sda_oe  <= ~nxt[BYTE_W-1];
                            rsel_q  <= ~rsel_q;
                            anc_pop <= is_anc;
                            st      <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= ST_SUB;
                        end
                    end
                    ST_SUB: if (rx_done) begin
                        ptr_q  <= sh;
                        sda_oe <= 1'b1;
                        st     <= ST_SUB_ACK;
                    end
                    ST_SUB_ACK: if (lev.scl_fall) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        wcnt   <= '0;
                        st     <= ST_WDATA;
                    end
                    ST_WDATA: if (rx_done) begin
                        sda_oe <= 1'b1;
                        if (wcnt == 2'd0) hi_q <= sh;
                        else if (wcnt == 2'd1) lo_q <= sh;
                        st <= ST_WDATA_ACK;
                    end
                    ST_WDATA_ACK: if (lev.scl_fall) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        if (wcnt == 2'd1) reg_we <= 1'b1;
                        if (wcnt != 2'd2) wcnt <= wcnt + 1'b1;
                        st <= ST_WDATA;
                    end
                    ST_RDATA: if (lev.scl_fall) begin
                        if (cnt == TX_LAST) begin
                            sda_oe <= 1'b0;
                            st     <= ST_RACK;
                        end else begin
                            sda_oe <= ~tx[BYTE_W-2];
                            tx     <= {tx[BYTE_W-3:0], 1'b0};
                            cnt    <= cnt + 1'b1;
                        end
                    end
                    ST_RACK: begin
                        if (lev.scl_rise) mack_q <= ~lev.sda;
                        if (lev.scl_fall) begin
                            cnt <= '0;
                            if (mack_q) begin
                                tx      <= nxt[BYTE_W-2:0];
                                sda_oe  <= ~nxt[BYTE_W-1];
                                rsel_q  <= ~rsel_q;
                                anc_pop <= is_anc;
                                st      <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: the write strobe lasts one cycle
    p_we_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);
    // R3: the strobe follows the SCL fall that closes an acknowledge
    p_we_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> $past(lev.scl_fall));
    // R8: pops are single pulses and only at the stream address
    p_pop_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        anc_pop |=> !anc_pop);
    p_pop_anc_r8: assert property (@(posedge clk) disable iff (rst)
        anc_pop |-> (reg_addr == ANC_ADDR));
    // R5: SDA drive changes only while SCL is low or on a bus condition
    p_oe_scl_low_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> ($past(!lev.scl_hi) || $past(lev.start) || $past(lev.stop)));
    // R10: a STOP always releases the line
    p_stop_release_r10: assert property (@(posedge clk) disable iff (rst)
        $past(lev.stop) |-> !sda_oe);

endmodule

// File: rtl/i2c_word_target.sv
module i2c_word_target
    import i2cw_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR    = 7'h34,
    parameter logic [BYTE_W-1:0] ANC_ADDR    = 8'h04,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_addr,
    output logic              reg_we,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] reg_rdata,
    output logic              anc_pop,
    input  logic [BYTE_W-1:0] anc_byte
);
    line_ev_t lev;

    i2cw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .lev   (lev)
    );

    i2cw_fsm #(.DEV_ADDR(DEV_ADDR), .ANC_ADDR(ANC_ADDR)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .lev       (lev),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .anc_pop   (anc_pop),
        .anc_byte  (anc_byte)
    );

endmodule

// File: tb/i2c_word_target_tb_top.sv
module i2c_word_target_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic bus_sda;
    logic sda_oe, reg_we, anc_pop;
    logic [7:0]  reg_addr, anc_byte;
    logic [15:0] reg_wdata, reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus_sda = sda_m & ~sda_oe;

    i2c_word_target dut_i (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(bus_sda), .sda_oe(sda_oe),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .anc_pop(anc_pop), .anc_byte(anc_byte)
    );

    // Register file and stream models
    logic [15:0]  wmem [256];
    logic [255:0] wvalid;
    logic [7:0]   anc_head;
    int we_cnt, pop_cnt, oe_cnt;
    logic [7:0]  last_wa;
    logic [15:0] last_wd;

    function automatic logic [15:0] dflt(input logic [7:0] a);
        return {a, ~a};
    endfunction

    assign reg_rdata = wvalid[reg_addr] ? wmem[reg_addr] : dflt(reg_addr);
    assign anc_byte  = anc_head;

    always @(posedge clk) begin
        if (rst) begin
            wvalid <= '0; anc_head <= 8'hA0;
            we_cnt <= 0; pop_cnt <= 0; oe_cnt <= 0;
            last_wa <= '0; last_wd <= '0;
        end else begin
            if (reg_we) begin
                we_cnt <= we_cnt + 1;
                last_wa <= reg_addr; last_wd <= reg_wdata;
                wvalid[reg_addr] <= 1'b1; wmem[reg_addr] <= reg_wdata;
            end
            if (anc_pop) begin
                pop_cnt <= pop_cnt + 1;
                anc_head <= anc_head + 8'd1;
            end
            if (sda_oe) oe_cnt <= oe_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    task automatic bit_w(input logic b);
        sda_m = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bit_r(output logic b);
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = bus_sda; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) bit_w(b[i]);
        bit_r(x);
        ack = ~x;
    endtask

    task automatic recv(input logic mack, output logic [7:0] b);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            bit_r(x);
            b[i] = x;
        end
        bit_w(~mack);
    endtask

    logic [7:0] got [8];
    logic       all_ack;

    // Read frame, with or without a sub-address phase; NACK on the last byte
    task automatic rd_frame(input logic with_sub, input logic [7:0] sub, input int n);
        logic a;
        all_ack = 1'b1;
        bus_start;
        if (with_sub) begin
            send(8'h68, a); all_ack &= a;
            send(sub, a);   all_ack &= a;
            bus_start;
        end
        send(8'h69, a); all_ack &= a;
        for (int i = 0; i < n; i++) recv(i < n - 1, got[i]);
        bus_stop;
    endtask

    task automatic wr_frame(input logic [7:0] sub, input logic [15:0] w);
        logic a;
        all_ack = 1'b1;
        bus_start;
        send(8'h68, a); all_ack &= a;
        send(sub, a);   all_ack &= a;
        send(w[15:8], a); all_ack &= a;
        send(w[7:0], a);  all_ack &= a;
        bus_stop;
    endtask

    task automatic t_reset;
        wq(3);
        chk("R1 sda_oe", 32'(sda_oe), 0);
        chk("R1 reg_we", 32'(reg_we), 0);
        chk("R1 anc_pop", 32'(anc_pop), 0);
    endtask

    task automatic t_bad_addr;
        logic a;
        int o, w;
        o = oe_cnt; w = we_cnt;
        bus_start;
        send(8'h6A, a);
        chk("R2 foreign address nack", 32'(a), 0);
        send(8'h10, a);
        send(8'h55, a);
        bus_stop;
        chk("R2 no drive after foreign address", 32'(oe_cnt - o), 0);
        chk("R2 no write after foreign address", 32'(we_cnt - w), 0);
    endtask

    task automatic t_write;
        logic a, acc;
        int w;
        w = we_cnt; acc = 1'b1;
        bus_start;
        send(8'h68, a);
        chk("R2 own address ack", 32'(a), 1);
        send(8'h30, a); acc &= a;
        send(8'hDE, a); acc &= a;
        chk("R3 no strobe before low byte", 32'(we_cnt - w), 0);
        send(8'hAD, a); acc &= a;
        bus_stop;
        chk("R3 bytes acked", 32'(acc), 1);
        chk("R3 one strobe", 32'(we_cnt - w), 1);
        chk("R3 strobe address", 32'(last_wa), 32'h30);
        chk("R3 strobe data", 32'(last_wd), 32'hDEAD);
    endtask

    task automatic t_extra;
        logic a, acc;
        int w;
        w = we_cnt; acc = 1'b1;
        bus_start;
        send(8'h68, a); acc &= a;
        send(8'h31, a); acc &= a;
        send(8'h12, a); acc &= a;
        send(8'h34, a); acc &= a;
        send(8'h56, a); acc &= a;
        send(8'h78, a); acc &= a;
        send(8'h9A, a); acc &= a;
        bus_stop;
        chk("R4 extra bytes acked", 32'(acc), 1);
        chk("R4 single strobe", 32'(we_cnt - w), 1);
        chk("R4 word kept", 32'(last_wd), 32'h1234);
    endtask

    task automatic t_read;
        rd_frame(1'b1, 8'h30, 2);
        chk("R5 read ack", 32'(all_ack), 1);
        chk("R5 high byte", 32'(got[0]), 32'hDE);
        chk("R5 low byte", 32'(got[1]), 32'hAD);
        rd_frame(1'b1, 8'h12, 2);
        chk("R5 default word", {16'h0, got[0], got[1]}, 32'(dflt(8'h12)));
    endtask

    task automatic t_repeat;
        rd_frame(1'b0, 8'h00, 2);
        chk("R6 repeat read after read", {16'h0, got[0], got[1]}, 32'(dflt(8'h12)));
        wr_frame(8'h22, 16'hCAFE);
        rd_frame(1'b0, 8'h00, 2);
        chk("R6 repeat read after write", {16'h0, got[0], got[1]}, 32'hCAFE);
    endtask

    task automatic t_multi;
        rd_frame(1'b1, 8'h30, 5);
        for (int i = 0; i < 5; i++)
            chk("R7 alternating bytes", 32'(got[i]), (i % 2 == 0) ? 32'hDE : 32'hAD);
    endtask

    task automatic t_anc;
        logic [7:0] h;
        int p;
        h = anc_head; p = pop_cnt;
        rd_frame(1'b1, 8'h04, 4);
        for (int i = 0; i < 4; i++)
            chk("R8 stream byte", 32'(got[i]), 32'(h + 8'(i)));
        chk("R8 one pop per byte", 32'(pop_cnt - p), 4);
    endtask

    task automatic t_nack;
        logic a, x;
        logic [7:0] h, b;
        int p, o;
        h = anc_head; p = pop_cnt;
        bus_start;
        send(8'h68, a); send(8'h04, a);
        bus_start;
        send(8'h69, a);
        recv(1'b0, b);
        chk("R9 byte before nack", 32'(b), 32'(h));
        o = oe_cnt;
        for (int i = 0; i < 9; i++) bit_r(x);
        chk("R9 no drive after nack", 32'(oe_cnt - o), 0);
        chk("R9 no pop after nack", 32'(pop_cnt - p), 1);
        bus_stop;
    endtask

    task automatic t_abort;
        logic a;
        int w;
        w = we_cnt;
        bus_start;
        send(8'h68, a); send(8'h50, a); send(8'hAB, a);
        bus_stop;
        chk("R10 stop cancels write", 32'(we_cnt - w), 0);
        rd_frame(1'b1, 8'h50, 2);
        chk("R10 register untouched", {16'h0, got[0], got[1]}, 32'(dflt(8'h50)));
    endtask

    initial begin
        wq(5);
        rst = 1'b0;
        t_reset;
        t_bad_addr;
        t_write;
        t_extra;
        t_read;
        t_repeat;
        t_multi;
        t_anc;
        t_nack;
        t_abort;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule